// File: doc/BRIEF.md
# Register-Backed Page Translation Unit

This block maps a 16-bit virtual address onto a 15-bit physical address. The mapping table sits entirely in flip-flops, with one entry for each virtual page, so a lookup never touches memory. Each entry holds a 3-bit frame number and a resident flag. Software fills the table through a write port when a process starts. After that, each request that carries a valid strobe returns a registered result one cycle later.

The top four address bits choose the page. The low twelve bits pass through unchanged as the offset, and the frame number from the entry is placed above them. If the selected entry is not resident, the block gives no address. It raises a fault flag and reports the page number that faulted. The fault flag is the block's only response to a fault.

Top module: `pgx_xlate`

## Requirements
- R1: A request to a resident page produces `rsp_ok`=1 one cycle later, with `rsp_paddr` = {frame[2:0], vaddr[11:0]}. Example: page 0 holding frame 2 maps address 0 to 8192, and page 5 holding frame 3 maps 20500 to 12308.
- R2: A request to a page whose resident flag is 0 produces `rsp_fault`=1 one cycle later, with `rsp_fault_page` = vaddr[15:12] and `rsp_ok`=0.
- R3: `rsp_ok` and `rsp_fault` are never 1 together. Both are 0 in any cycle that follows a cycle with no request.
- R4: After reset, every entry is non-resident, so every request faults until its entry has been written.
- R5: When `tbl_we`=1, entry `tbl_page` takes frame `tbl_frame` and resident flag `tbl_present`. Writing `tbl_present`=0 removes the mapping.
- R6: When a write and a request to the same page fall in the same cycle, the response uses the entry as it stood before that write. The new value applies from the next request on.
- R7: A write to one page leaves every other page's translation unchanged.
- R8: While reset is asserted, `rsp_ok` and `rsp_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_page | input | 4 | Page index to write |
| tbl_frame | input | 3 | Frame number to store |
| tbl_present | input | 1 | Resident flag to store |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 16 | Virtual address |
| rsp_ok | output | 1 | Translation valid |
| rsp_paddr | output | 15 | Physical address |
| rsp_fault | output | 1 | Page fault |
| rsp_fault_page | output | 4 | Faulting page number |

## Verification
The hardest case to reach is a write and a request that land on the same page in the same cycle. This is worst when the write flips the resident flag, because the response must then follow the old state in both directions. The bench sets up this collision directly for a map-to-unmap change and for an unmap-to-map change. It also sends random traffic in which the page fields of the write and the request are drawn from a small range, so collisions happen often. A reference model in the bench updates its table only after it has computed each response.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int VA_W   = 16;
  localparam int OFF_W  = 12;
  localparam int PAGE_W = VA_W - OFF_W;
  localparam int FRM_W  = 3;
  localparam int PA_W   = FRM_W + OFF_W;
  localparam int NPAGES = 1 << PAGE_W;

  typedef struct packed {
    logic             present;
    logic [FRM_W-1:0] frame;
  } pte_t;

  function automatic logic [PAGE_W-1:0] va_page(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [PA_W-1:0] make_pa(input logic [FRM_W-1:0] f,
                                              input logic [VA_W-1:0] va);
    return {f, va[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/pgx_table.sv
module pgx_table
  import pgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PAGE_W-1:0] wpage,
  input  pte_t              wdata,
  input  logic [PAGE_W-1:0] rpage,
  output pte_t              rdata
);
  pte_t ent [NPAGES];

  for (genvar g = 0; g < NPAGES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) ent[g] <= '0;
      else if (we && wpage == PAGE_W'(g)) ent[g] <= wdata;
    end
  end

  assign rdata = ent[rpage];
endmodule

// File: rtl/pgx_resp.sv
module pgx_resp
  import pgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [VA_W-1:0]   vaddr,
  input  pte_t              pte,
  output logic              ok,
  output logic [PA_W-1:0]   paddr,
  output logic              fault,
  output logic [PAGE_W-1:0] fpage
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok <= 1'b0; fault <= 1'b0; paddr <= '0; fpage <= '0;
    end else begin
      ok    <= valid &&  pte.present;
      fault <= valid && !pte.present;
      if (valid) begin
        paddr <= pte.present ? make_pa(pte.frame, vaddr) : '0;
        fpage <= va_page(vaddr);
      end
    end
  end
endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
  import pgx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tbl_we,
  input  logic [3:0]  tbl_page,
  input  logic [2:0]  tbl_frame,
  input  logic        tbl_present,
  input  logic        req_valid,
  input  logic [15:0] req_vaddr,
  output logic        rsp_ok,
  output logic [14:0] rsp_paddr,
  output logic        rsp_fault,
  output logic [3:0]  rsp_fault_page
);
  pte_t lookup_pte;
  pte_t wr_pte;
  logic [PAGE_W-1:0] lookup_page;

  assign wr_pte      = '{present: tbl_present, frame: tbl_frame};
  assign lookup_page = va_page(req_vaddr);

  pgx_table u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .wpage(tbl_page),
    .wdata(wr_pte), .rpage(lookup_page), .rdata(lookup_pte)
  );

  pgx_resp u_rsp (
    .clk(clk), .rst_n(rst_n), .valid(req_valid), .vaddr(req_vaddr),
    .pte(lookup_pte), .ok(rsp_ok), .paddr(rsp_paddr),
    .fault(rsp_fault), .fpage(rsp_fault_page)
  );
endmodule

// File: rtl/pgx_xlate_chk.sv
module pgx_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [15:0] req_vaddr,
  input logic        rsp_ok,
  input logic [14:0] rsp_paddr,
  input logic        rsp_fault,
  input logic [3:0]  rsp_fault_page
);
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_ok && rsp_fault)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ok && !rsp_fault); // R3
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_ok || rsp_fault)); // R1
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_ok || rsp_paddr[11:0] == $past(req_vaddr[11:0]))); // R1
  AST_FAULT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_fault || rsp_fault_page == $past(req_vaddr[15:12]))); // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !rsp_ok && !rsp_fault); // R8
endmodule

bind pgx_xlate pgx_xlate_chk u_chk (.*);

// File: tb/pgx_xlate_test.sv
module pgx_xlate_test;
  logic clk = 0, rst_n = 0;
  logic tbl_we = 0, tbl_present = 0, req_valid = 0;
  logic [3:0] tbl_page = 0;
  logic [2:0] tbl_frame = 0;
  logic [15:0] req_vaddr = 0;
  logic rsp_ok, rsp_fault;
  logic [14:0] rsp_paddr;
  logic [3:0] rsp_fault_page;
  int vecs = 0, bad = 0;
  logic [2:0] m_frm [16];
  logic       m_prs [16];

  always #2 clk = ~clk;

  pgx_xlate uut (.*);

  function automatic logic [14:0] exp_pa(input logic [2:0] f, input logic [15:0] va);
    return 15'(f) * 15'd4096 + 15'(va % 16'd4096);
  endfunction

  task automatic cmp(input string r, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  // one cycle: optional write and optional request; check response; update model after
  task automatic step(input logic we, input logic [3:0] wp, input logic [2:0] wf,
                      input logic wpr, input logic rv, input logic [15:0] va,
                      input string r);
    logic [3:0] pg;
    tbl_we = we; tbl_page = wp; tbl_frame = wf; tbl_present = wpr;
    req_valid = rv; req_vaddr = va;
    pg = va[15:12];
    @(posedge clk); #1;
    tbl_we = 0; req_valid = 0;
    if (rv) begin
      if (m_prs[pg]) begin
        cmp({r, " ok"}, 32'(rsp_ok), 1);
        cmp({r, " fault"}, 32'(rsp_fault), 0);
        cmp({r, " paddr"}, 32'(rsp_paddr), 32'(exp_pa(m_frm[pg], va)));
      end else begin
        cmp({r, " fault"}, 32'(rsp_fault), 1);
        cmp({r, " ok"}, 32'(rsp_ok), 0);
        cmp({r, " fpage"}, 32'(rsp_fault_page), 32'(pg));
      end
    end else begin
      cmp({r, " idle"}, 32'({rsp_ok, rsp_fault}), 0);
    end
    if (we) begin m_frm[wp] = wf; m_prs[wp] = wpr; end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog act=hang exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin m_frm[i] = 0; m_prs[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    cmp("R8 reset quiet", 32'({rsp_ok, rsp_fault}), 0);
    rst_n = 1;
    // R4: all pages fault after reset
    for (int p = 0; p < 16; p++) step(0, 0, 0, 0, 1, 16'(p * 4096 + 7), "R4");
    // R5/R1: example mappings
    step(1, 4'd0, 3'd2, 1, 0, 0, "R5 w");
    step(1, 4'd5, 3'd3, 1, 0, 0, "R5 w");
    step(0, 0, 0, 0, 1, 16'd0, "R1 va0");
    cmp("R1 8192", 32'(rsp_paddr), 8192);
    step(0, 0, 0, 0, 1, 16'd20500, "R1 va20500");
    cmp("R1 12308", 32'(rsp_paddr), 12308);
    step(0, 0, 0, 0, 0, 0, "R3 idle");
    // R6: same-page collision, both directions
    step(1, 4'd5, 3'd1, 0, 1, 16'd20500, "R6 unmap-old");
    step(0, 0, 0, 0, 1, 16'd20500, "R6 unmapped");
    step(1, 4'd5, 3'd6, 1, 1, 16'h5ABC, "R6 map-old");
    step(0, 0, 0, 0, 1, 16'h5ABC, "R6 mapped");
    // R7: write other page, page 0 unaffected
    step(1, 4'd9, 3'd7, 1, 1, 16'h0FFF, "R7 neighbour");
    step(0, 0, 0, 0, 1, 16'h0FFF, "R7 after");
    // R2: unmap explicitly then fault
    step(1, 4'd0, 3'd0, 0, 0, 0, "R5 unmap");
    step(0, 0, 0, 0, 1, 16'h0123, "R2 fault");
    // random, collisions frequent
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] wp, rp;
      wp = 4'($urandom_range(0, 3)) + ((i % 4 == 0) ? 4'($urandom_range(0, 12)) : 4'd0);
      rp = 4'($urandom_range(0, 3)) + ((i % 5 == 0) ? 4'($urandom_range(0, 12)) : 4'd0);
      step(1'($urandom_range(0, 1)), wp, 3'($urandom_range(0, 7)),
           ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0),
           {rp, 12'($urandom)}, "R1R2R6R7 rand");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule